// File: doc/BRIEF.md
# Packet and Word Token Rate Limiter

This block shapes the traffic leaving one output port with a token bucket. Every accepted packet is charged two amounts at once: a fixed per-packet cost that covers framing overhead the payload count misses, and a per-word cost multiplied by the packet length in 8-byte words. The bucket refills by a fixed number of tokens on every clock cycle. The stored credit is capped at a configured limit, and that cap sets the largest burst the port may send after an idle stretch.

The per-packet cost and the limit are given in coarse units worth 256 raw tokens each. The per-word cost is given in raw tokens. Software sets the three configuration values. A per-word cost of zero turns the block into a pure packets-per-second limiter. For a bit-rate limit, the per-packet cost can be set to cover the 24 bytes of gap, preamble and CRC that precede and follow every frame.

Packet starts arrive on a valid/ready handshake. A start is consumed only in a cycle where `sop_valid` and `sop_ready` are both high. `sop_ready` depends only on the stored credit and the configuration, never on `sop_valid`. While `sop_ready` is low, the source may hold, drop or change its request and its length, and nothing is consumed or charged.

Top module: `pkt_word_shaper`

## Requirements
- R1: After reset the stored credit is zero and `sop_ready` is high.
- R2: In a cycle with no accepted start, the credit grows by REFILL tokens (default 16). It never rises above `cfg_limit` × 256.
- R3: An accepted start is charged `cfg_pkt_cost` × 256 + `cfg_word_cost` × `sop_words` raw tokens.
- R4: `sop_ready` is high exactly when the credit is non-negative, except in the unlimited case of R6. The charge of an accepted start may drive the credit negative.
- R5: With `cfg_word_cost` at zero, the spacing between back-to-back accepted starts is the same for every packet length.
- R6: When `cfg_pkt_cost`, `cfg_word_cost` and `cfg_limit` are all zero, `sop_ready` stays high whatever the traffic.
- R7: A start offered while `sop_ready` is low is not consumed. Its length has no effect on the credit.
- R8: In the cycle of an accepted start, the new credit is min(credit + REFILL, limit × 256) minus the charge. Refill and clamp are applied before the charge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the refill is applied on every rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pkt_cost | input | PKT_COST_W | Fixed cost of each packet, in units of 256 tokens |
| cfg_word_cost | input | WORD_COST_W | Cost of each 8-byte word, in raw tokens |
| cfg_limit | input | LIMIT_W | Bucket ceiling, in units of 256 tokens |
| sop_valid | input | 1 | A packet start is offered |
| sop_words | input | LEN_W | Length of the offered packet in 8-byte words |
| sop_ready | output | 1 | Send permit; a start is consumed when this and `sop_valid` are both high |

## Verification
A stored credit that is wrong shows up at `sop_ready` as a permit that comes too early or too late. A wrong clamp at the ceiling only shows after an idle stretch, as a burst that runs one or more packets longer or shorter than expected. A charge with the wrong weight or scale shifts the gap between back-to-back starts in the cycle right after the next accepted start. A dropped refill freezes the port within about one packet time. The bench follows the credit arithmetically from the requirements and compares the permit on every cycle. So any divergence is caught within a few cycles of the faulty update, and directed measurements of gap and burst length pin down scale errors that the sweep alone could mask.

// File: rtl/rl_shaper_pkg.sv
package rl_shaper_pkg;

  // coarse unit of cost and limit fields: 2**SCALE_SHIFT raw tokens
  localparam int unsigned SCALE_SHIFT    = 8;
  // raw tokens added by the refill on every clock cycle
  localparam int unsigned DEFAULT_REFILL = 16;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rl_charge_calc.sv
// Combinational charge for one packet start: fixed part scaled up, plus words times word cost.
module rl_charge_calc #(
  parameter int unsigned PKT_COST_W  = 12,
  parameter int unsigned WORD_COST_W = 12,
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned SCALE_SHIFT = 8,
  parameter int unsigned CHG_W       = 21
) (
  input  logic [PKT_COST_W-1:0]  pkt_cost,
  input  logic [WORD_COST_W-1:0] word_cost,
  input  logic [LEN_W-1:0]       words,
  output logic [CHG_W-1:0]       charge
);

  logic [CHG_W-1:0] fixed_part;
  logic [CHG_W-1:0] word_part;

  assign fixed_part = CHG_W'(pkt_cost) << SCALE_SHIFT;
  assign word_part  = CHG_W'(word_cost) * CHG_W'(words);
  assign charge     = fixed_part + word_part;

endmodule

// File: rtl/rl_credit_bucket.sv
// Signed credit register: clamp after refill, then subtract the charge of an accepted start.
module rl_credit_bucket #(
  parameter int unsigned CREDIT_W    = 26,
  parameter int unsigned CHG_W       = 21,
  parameter int unsigned LIMIT_W     = 16,
  parameter int unsigned SCALE_SHIFT = 8,
  parameter int unsigned REFILL      = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LIMIT_W-1:0]         limit,
  input  logic                       take,
  input  logic [CHG_W-1:0]           charge,
  output logic signed [CREDIT_W-1:0] credit_q
);

  localparam logic signed [CREDIT_W-1:0] REFILL_C = CREDIT_W'(REFILL);

  logic signed [CREDIT_W-1:0] cap_c;
  logic signed [CREDIT_W-1:0] grown;
  logic signed [CREDIT_W-1:0] capped;
  logic signed [CREDIT_W-1:0] charge_s;
  logic signed [CREDIT_W-1:0] credit_d;

  assign cap_c    = $signed({{(CREDIT_W-LIMIT_W){1'b0}}, limit} << SCALE_SHIFT);
  assign charge_s = $signed({{(CREDIT_W-CHG_W){1'b0}}, charge});
  assign grown    = credit_q + REFILL_C;

  always_comb begin
    capped = (grown > cap_c) ? cap_c : grown;
    if (take) credit_d = capped - charge_s;
    else      credit_d = capped;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) credit_q <= '0;
    else        credit_q <= credit_d;
  end

  AST_IDLE_GROWTH_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (credit_q <= $past(credit_q) + REFILL_C)); // R2

  AST_CAP_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && $past(!take)) |=> (credit_q <= $past(cap_c) || credit_q <= $past(credit_q))); // R2

  AST_CHARGE_DEDUCTED: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (credit_q + $past(charge_s) <= $past(credit_q) + REFILL_C)); // R3

endmodule

// File: rtl/rl_permit_gen.sv
// Send permit from the credit sign, with the all-zero configuration as an open port.
module rl_permit_gen #(
  parameter int unsigned CREDIT_W    = 26,
  parameter int unsigned PKT_COST_W  = 12,
  parameter int unsigned WORD_COST_W = 12,
  parameter int unsigned LIMIT_W     = 16
) (
  input  logic signed [CREDIT_W-1:0] credit_q,
  input  logic [PKT_COST_W-1:0]      pkt_cost,
  input  logic [WORD_COST_W-1:0]     word_cost,
  input  logic [LIMIT_W-1:0]         limit,
  output logic                       unlimited,
  output logic                       permit
);

  assign unlimited = ~|{pkt_cost, word_cost, limit};
  assign permit    = unlimited | ~credit_q[CREDIT_W-1];

endmodule

// File: rtl/pkt_word_shaper.sv
module pkt_word_shaper #(
  parameter int unsigned PKT_COST_W  = 12,
  parameter int unsigned WORD_COST_W = 12,
  parameter int unsigned LIMIT_W     = 16,
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned REFILL      = rl_shaper_pkg::DEFAULT_REFILL
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PKT_COST_W-1:0]  cfg_pkt_cost,
  input  logic [WORD_COST_W-1:0] cfg_word_cost,
  input  logic [LIMIT_W-1:0]     cfg_limit,
  input  logic                   sop_valid,
  input  logic [LEN_W-1:0]       sop_words,
  output logic                   sop_ready
);

  import rl_shaper_pkg::*;

  localparam int unsigned CHG_W    = max2(PKT_COST_W + SCALE_SHIFT, WORD_COST_W + LEN_W) + 1;
  localparam int unsigned CREDIT_W = max2(LIMIT_W + SCALE_SHIFT, CHG_W) + 2;
  localparam logic signed [CREDIT_W-1:0] FLOOR_C =
    $signed(~(CREDIT_W'(1) << CHG_W) + CREDIT_W'(1));

  logic [CHG_W-1:0]           charge;
  logic signed [CREDIT_W-1:0] credit_q;
  logic                       take;
  logic                       unlimited;

  assign take = sop_valid & sop_ready;

  rl_charge_calc #(
    .PKT_COST_W (PKT_COST_W),
    .WORD_COST_W(WORD_COST_W),
    .LEN_W      (LEN_W),
    .SCALE_SHIFT(SCALE_SHIFT),
    .CHG_W      (CHG_W)
  ) u_charge (
    .pkt_cost (cfg_pkt_cost),
    .word_cost(cfg_word_cost),
    .words    (sop_words),
    .charge   (charge)
  );

  rl_credit_bucket #(
    .CREDIT_W   (CREDIT_W),
    .CHG_W      (CHG_W),
    .LIMIT_W    (LIMIT_W),
    .SCALE_SHIFT(SCALE_SHIFT),
    .REFILL     (REFILL)
  ) u_bucket (
    .clk     (clk),
    .rst_n   (rst_n),
    .limit   (cfg_limit),
    .take    (take),
    .charge  (charge),
    .credit_q(credit_q)
  );

  rl_permit_gen #(
    .CREDIT_W   (CREDIT_W),
    .PKT_COST_W (PKT_COST_W),
    .WORD_COST_W(WORD_COST_W),
    .LIMIT_W    (LIMIT_W)
  ) u_permit (
    .credit_q (credit_q),
    .pkt_cost (cfg_pkt_cost),
    .word_cost(cfg_word_cost),
    .limit    (cfg_limit),
    .unlimited(unlimited),
    .permit   (sop_ready)
  );

  AST_NEGATIVE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_q < 0 && !unlimited) |-> !sop_ready); // R4

  AST_CREDIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    credit_q >= FLOOR_C); // R4

  AST_UNLIMITED_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    unlimited |-> sop_ready); // R6

  AST_STALL_NO_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sop_valid && !sop_ready) |=> (credit_q <= $past(credit_q) + $signed(CREDIT_W'(REFILL))
                                   && credit_q >= $past(credit_q))); // R7

endmodule

// File: tb/tb_pkt_word_shaper.sv
module tb_pkt_word_shaper;

  localparam int CLK_PERIOD = 10;
  localparam int RF = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_pkt_cost = '0;
  logic [3:0] cfg_word_cost = '0;
  logic [2:0] cfg_limit = '0;
  logic       sop_valid = 1'b0;
  logic [2:0] sop_words = '0;
  logic       sop_ready;

  int checks = 0;
  int fails = 0;
  longint mc;          // model credit after the coming edge is applied
  int pk, wc, lim;
  bit obs_ready;
  logic [7:0] lfsr = 8'hA5;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_word_shaper #(
    .PKT_COST_W(4), .WORD_COST_W(4), .LIMIT_W(3), .LEN_W(3)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_pkt_cost(cfg_pkt_cost), .cfg_word_cost(cfg_word_cost), .cfg_limit(cfg_limit),
    .sop_valid(sop_valid), .sop_words(sop_words), .sop_ready(sop_ready)
  );

  task automatic check_bit(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (pk=%0d wc=%0d lim=%0d)", req, act, exp, pk, wc, lim);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit model_unl();
    return (pk == 0 && wc == 0 && lim == 0);
  endfunction

  function automatic void model_adv(input bit acc, input int ln);
    longint nxt;
    nxt = mc + RF;
    if (nxt > lim * 256) nxt = lim * 256;
    if (acc) nxt = nxt - (pk * 256 + wc * ln);
    mc = nxt;
  endfunction

  // one cycle at the falling edge: check the permit, drive the request, advance the model
  task automatic cyc(input bit v, input int ln, input string req);
    bit exp_r;
    @(negedge clk);
    exp_r = model_unl() || (mc >= 0);
    obs_ready = sop_ready;
    check_bit(sop_ready, exp_r, req);
    sop_valid = v;
    sop_words = 3'(ln);
    model_adv(v && exp_r, ln);
  endtask

  task automatic do_reset(input int p, input int w, input int l);
    pk = p; wc = w; lim = l;
    @(negedge clk);
    rst_n = 1'b0;
    sop_valid = 1'b0;
    cfg_pkt_cost = 4'(p);
    cfg_word_cost = 4'(w);
    cfg_limit = 3'(l);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mc = 0;
    check_bit(sop_ready, 1'b1, "R1 reset permit");
    model_adv(1'b0, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int pv[4];
    int wv[4];
    int lv[4];
    pv = '{0, 1, 3, 15};
    wv = '{0, 1, 5, 15};
    lv = '{0, 1, 4, 7};

    // R3: one start of 5 words, pkt cost 1, word cost 3 -> charge 271; count closed cycles
    begin
      int lows;
      int c0;
      do_reset(1, 3, 7);
      cyc(1, 5, "R3 accept");
      lows = 0;
      for (int i = 0; i < 100; i++) begin
        cyc(0, 0, "R3 recover");
        if (obs_ready) break;
        lows++;
      end
      c0 = 2 * RF - (256 + 3 * 5);          // credit 16 at acceptance, refill then charge
      check_int(lows, (-c0 + RF - 1) / RF, "R3 R8 closed cycles after charge");
    end

    // R5: word cost zero, pkt cost 2: gaps after a 1-word and a 7-word packet match
    begin
      int n;
      int t;
      int at[4];
      n = 0; t = 0;
      do_reset(2, 0, 7);
      for (int i = 0; i < 200 && n < 4; i++) begin
        cyc(1, (n == 1) ? 1 : 7, "R5 stream");
        if (obs_ready) begin at[n] = t; n++; end
        t++;
      end
      check_int(n, 4, "R5 accept count");
      check_int(at[2] - at[1], (2 * 256 - RF + RF - 1) / RF + 1, "R5 gap after 1-word packet");
      check_int(at[3] - at[2], at[2] - at[1], "R5 gap independent of length");
    end

    // R2: ceiling 256 tokens, charge 105 per start: a full bucket allows exactly 3 starts
    begin
      int n;
      do_reset(0, 15, 1);
      for (int i = 0; i < 40; i++) cyc(0, 0, "R2 idle fill");
      n = 0;
      for (int i = 0; i < 20; i++) begin
        cyc(1, 7, "R2 burst");
        if (!obs_ready) break;
        n++;
      end
      // 256 -> 151 -> 62 -> -27
      check_int(n, 3, "R2 burst length under ceiling");
    end

    // R6: all-zero configuration never closes
    begin
      int lows;
      lows = 0;
      do_reset(0, 0, 0);
      for (int i = 0; i < 40; i++) begin
        cyc(1, i % 8, "R6 unlimited");
        if (!obs_ready) lows++;
      end
      check_int(lows, 0, "R6 permit never low");
    end

    // sweep: every configuration of the small grid with pseudo-random traffic
    foreach (pv[a]) foreach (wv[b]) foreach (lv[c]) begin
      do_reset(pv[a], wv[b], lv[c]);
      for (int i = 0; i < 180; i++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        cyc(lfsr[0] | lfsr[1], int'(lfsr[4:2]), "R2 R3 R4 R7 R8 sweep");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule